// File: doc/BRIEF.md
# Serial Control Port Register Bank

This block takes 16-bit control words from a three-wire serial link (bit clock, data, latch strobe) and turns them into register state for an audio converter's datapath. The link runs from a host microcontroller with no relation to the system clock. Each of the three wires is oversampled in the system clock domain through a two-flop synchronizer. Bits are taken on rising edges of the serial clock, most significant first. A rising edge on the latch strobe closes the frame.

A frame of exactly sixteen bits is decoded by its two lowest bits. The fourteen bits above them are the payload. That payload goes to the left volume target, the right volume target or the control register. The control register drives the interpolation rate, the word length, mute, the serial audio format and the de-emphasis curve. Four of those outputs are also ORed with board-level pins. A volume write raises a one-cycle "new target" strobe for the ramp logic downstream. Setting the soft-reset bit gives a one-cycle datapath reset, and the bit does not stay set. A frame of the wrong length is dropped and flagged.

Top module: `sctl_regbank`

## Requirements
- R1: A frame is the bits sampled on rising serial-clock edges since the previous latch rise, shifted in most significant bit first. The serial clock must stay at least 3 system clock periods at each level. A latch rising edge with exactly 16 bits in the frame applies the word, with payload = word[15:2] and address = word[1:0].
- R2: Address 2'b00 loads the payload into the left volume output and pulses vol_left_new_o high for exactly one cycle.
- R3: Address 2'b10 loads the payload into the right volume output and pulses vol_right_new_o high for exactly one cycle.
- R4: Address 2'b01 loads the control register. Its payload bit fields are: bit 11 is 2x mode, bit 10 is 4x mode, bits 9:8 are word length, bit 7 is soft reset, bit 6 is mute, bits 5:4 are serial format and bits 3:2 are de-emphasis. Word length and de-emphasis appear unchanged on wlen_o and deemph_o.
- R5: Address 2'b11 changes no register and raises no strobe.
- R6: A latch rising edge after any bit count other than 16 discards the frame, leaves all registers unchanged and pulses frame_err_o for exactly one cycle.
- R7: x2_mode_o, x4_mode_o, mute_o and fmt_o are the bitwise OR of the stored control field and the matching pin input. A pin change shows at the output in the same cycle.
- R8: A control write with payload bit 7 set pulses dp_reset_o for exactly one cycle. The stored bit reads as zero afterwards.
- R9: After reset, every register output, strobe and the error flag are zero.
- R10: Strobes and updated register values appear on the 4th rising system clock edge after the latch strobe rises at the input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_lat_i | input | 1 | Latch strobe, rising edge ends a frame |
| pin_x2_i | input | 1 | Board pin ORed into 2x mode |
| pin_x4_i | input | 1 | Board pin ORed into 4x mode |
| pin_mute_i | input | 1 | Board pin ORed into mute |
| pin_fmt_i | input | 2 | Board pins ORed into serial format |
| vol_left_o | output | 14 | Left volume target |
| vol_right_o | output | 14 | Right volume target |
| vol_left_new_o | output | 1 | One-cycle strobe on left volume write |
| vol_right_new_o | output | 1 | One-cycle strobe on right volume write |
| x2_mode_o | output | 1 | 2x interpolation mode |
| x4_mode_o | output | 1 | 4x interpolation mode |
| wlen_o | output | 2 | Word length: 00=24, 01=20, 10=16 |
| mute_o | output | 1 | Mute request |
| fmt_o | output | 2 | Format: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP |
| deemph_o | output | 2 | De-emphasis: 00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz |
| dp_reset_o | output | 1 | One-cycle datapath reset pulse |
| frame_err_o | output | 1 | One-cycle pulse on a badly sized frame |

## Verification
Every registered result of a frame is due on the fourth system clock edge after the latch rises at the pin. The bench drives the latch on a falling edge, counts four rising edges and samples on the next falling edge. It then checks the strobes again one falling edge later to prove they last a single cycle. The pin-OR outputs are combinational, so the bench checks them on the falling edge right after it changes a pin. Serial data changes only while the serial clock is low, and each serial clock level is held for six system cycles, which keeps synchronizer skew out of the captured bits.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 2;
    localparam int PAY_W  = WORD_W - ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        ADR_VOL_L = 2'b00,
        ADR_CTRL  = 2'b01,
        ADR_VOL_R = 2'b10,
        ADR_NONE  = 2'b11
    } sctl_addr_e;

    localparam int B_X2   = 11;
    localparam int B_X4   = 10;
    localparam int B_WLEN = 8;
    localparam int B_SRST = 7;
    localparam int B_MUTE = 6;
    localparam int B_FMT  = 4;
    localparam int B_DEEM = 2;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int LANES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] async_i,
    output logic [LANES-1:0] lvl_o,
    output logic [LANES-1:0] rise_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign lvl_o[g]  = chain_q[STAGES-1];
        assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
    end
endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise_i,
    input  logic              bit_dat_i,
    input  logic              lat_rise_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o,
    output logic              frame_err_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic              vld;
        logic              err;
    } shift_st_t;

    shift_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.err = 1'b0;
        if (bit_rise_i) begin
            s_d.shreg = {s_q.shreg[WORD_W-2:0], bit_dat_i};
            if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
        end
        if (lat_rise_i) begin
            if (s_q.cnt == CNT_FULL) begin
                s_d.vld  = 1'b1;
                s_d.word = s_q.shreg;
            end else begin
                s_d.err = 1'b1;
            end
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_vld_o  = s_q.vld;
    assign word_o      = s_q.word;
    assign frame_err_o = s_q.err;

    // R6: a frame is either applied or rejected, never both
    a_r6_vld_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.vld && s_q.err));
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
    import sctl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_vld_i,
    input  logic [WORD_W-1:0]       word_i,
    input  logic                    err_i,
    output logic [WORD_W-ADDR_W-1:0] vol_l_o,
    output logic [WORD_W-ADDR_W-1:0] vol_r_o,
    output logic                    vol_l_new_o,
    output logic                    vol_r_new_o,
    output logic [WORD_W-ADDR_W-1:0] ctrl_o,
    output logic                    srst_o,
    output logic                    err_o
);
    localparam int PW = WORD_W - ADDR_W;

    typedef struct packed {
        logic [PW-1:0] vol_l;
        logic [PW-1:0] vol_r;
        logic [PW-1:0] ctrl;
        logic          vl_new;
        logic          vr_new;
        logic          srst;
        logic          err;
    } rf_st_t;

    rf_st_t r_d, r_q;
    sctl_addr_e    addr;
    logic [PW-1:0] pay;

    always_comb begin
        addr       = sctl_addr_e'(word_i[ADDR_W-1:0]);
        pay        = word_i[WORD_W-1:ADDR_W];
        r_d        = r_q;
        r_d.vl_new = 1'b0;
        r_d.vr_new = 1'b0;
        r_d.srst   = 1'b0;
        r_d.err    = err_i;
        if (word_vld_i) begin
            unique case (addr)
                ADR_VOL_L: begin
                    r_d.vol_l  = pay;
                    r_d.vl_new = 1'b1;
                end
                ADR_VOL_R: begin
                    r_d.vol_r  = pay;
                    r_d.vr_new = 1'b1;
                end
                ADR_CTRL: begin
                    r_d.ctrl         = pay;
                    r_d.ctrl[B_SRST] = 1'b0;
                    r_d.srst         = pay[B_SRST];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vol_l_o     = r_q.vol_l;
    assign vol_r_o     = r_q.vol_r;
    assign vol_l_new_o = r_q.vl_new;
    assign vol_r_new_o = r_q.vr_new;
    assign ctrl_o      = r_q.ctrl;
    assign srst_o      = r_q.srst;
    assign err_o       = r_q.err;

    // R2: left volume never changes without its strobe
    a_r2_left_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.vol_l) |-> r_q.vl_new);
    // R3: right volume never changes without its strobe
    a_r3_right_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.vol_r) |-> r_q.vr_new);
    // R5: an address of 11 leaves every register as it was
    a_r5_addr_none: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_i && word_i[ADDR_W-1:0] == 2'b11) |=>
        ($stable(r_q.vol_l) && $stable(r_q.vol_r) && $stable(r_q.ctrl) &&
         !r_q.vl_new && !r_q.vr_new && !r_q.srst));
    // R8: the datapath reset lasts a single cycle
    a_r8_srst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.srst |=> !r_q.srst);
    // R4: one frame reaches at most one register
    a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.vl_new, r_q.vr_new, r_q.srst}));
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
    import sctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_lat_i,
    input  logic              pin_x2_i,
    input  logic              pin_x4_i,
    input  logic              pin_mute_i,
    input  logic [1:0]        pin_fmt_i,
    output logic [PAY_W-1:0]  vol_left_o,
    output logic [PAY_W-1:0]  vol_right_o,
    output logic              vol_left_new_o,
    output logic              vol_right_new_o,
    output logic              x2_mode_o,
    output logic              x4_mode_o,
    output logic [1:0]        wlen_o,
    output logic              mute_o,
    output logic [1:0]        fmt_o,
    output logic [1:0]        deemph_o,
    output logic              dp_reset_o,
    output logic              frame_err_o
);
    localparam int LANES = 3;

    logic [LANES-1:0] lvl, rise;
    logic              word_vld, sh_err;
    logic [WORD_W-1:0] word;
    logic [PAY_W-1:0]  ctrl;

    sctl_sync #(.LANES(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_lat_i, ser_dat_i, ser_clk_i}),
        .lvl_o   (lvl),
        .rise_o  (rise)
    );

    sctl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_rise_i  (rise[0]),
        .bit_dat_i   (lvl[1]),
        .lat_rise_i  (rise[2]),
        .word_vld_o  (word_vld),
        .word_o      (word),
        .frame_err_o (sh_err)
    );

    sctl_regfile #(.WORD_W(WORD_W)) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_vld_i  (word_vld),
        .word_i      (word),
        .err_i       (sh_err),
        .vol_l_o     (vol_left_o),
        .vol_r_o     (vol_right_o),
        .vol_l_new_o (vol_left_new_o),
        .vol_r_new_o (vol_right_new_o),
        .ctrl_o      (ctrl),
        .srst_o      (dp_reset_o),
        .err_o       (frame_err_o)
    );

    assign x2_mode_o = ctrl[B_X2] | pin_x2_i;
    assign x4_mode_o = ctrl[B_X4] | pin_x4_i;
    assign mute_o    = ctrl[B_MUTE] | pin_mute_i;
    assign fmt_o     = ctrl[B_FMT+1:B_FMT] | pin_fmt_i;
    assign wlen_o    = ctrl[B_WLEN+1:B_WLEN];
    assign deemph_o  = ctrl[B_DEEM+1:B_DEEM];

    // R6: a rejected frame touches no volume register
    a_r6_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> (!vol_left_new_o && !vol_right_new_o && !dp_reset_o));
endmodule

// File: tb/sctl_regbank_bench.sv
module sctl_regbank_bench;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic pin_x2 = 1'b0, pin_x4 = 1'b0, pin_mute = 1'b0;
    logic [1:0] pin_fmt = 2'b00;
    logic [13:0] vol_l, vol_r;
    logic vl_new, vr_new, x2, x4, mute, dprst, ferr;
    logic [1:0] wlen, fmt, deem;

    int checks = 0;
    int errors = 0;
    logic [13:0] e_l = '0, e_r = '0, e_c = '0;
    logic e_vln, e_vrn, e_srst, e_err;

    always #4 clk = ~clk;

    sctl_regbank u_sctl_regbank (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_lat_i(ser_lat),
        .pin_x2_i(pin_x2), .pin_x4_i(pin_x4), .pin_mute_i(pin_mute), .pin_fmt_i(pin_fmt),
        .vol_left_o(vol_l), .vol_right_o(vol_r),
        .vol_left_new_o(vl_new), .vol_right_new_o(vr_new),
        .x2_mode_o(x2), .x4_mode_o(x4), .wlen_o(wlen), .mute_o(mute),
        .fmt_o(fmt), .deemph_o(deem), .dp_reset_o(dprst), .frame_err_o(ferr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] pay_of(input logic [15:0] w);
        return w[15:2];
    endfunction

    task automatic check_regs(input string tag);
        chk({tag, " R2 vol_left"}, 32'(vol_l), 32'(e_l));
        chk({tag, " R3 vol_right"}, 32'(vol_r), 32'(e_r));
        chk({tag, " R7 x2"}, 32'(x2), 32'(e_c[11] | pin_x2));
        chk({tag, " R7 x4"}, 32'(x4), 32'(e_c[10] | pin_x4));
        chk({tag, " R4 wlen"}, 32'(wlen), 32'(e_c[9:8]));
        chk({tag, " R7 mute"}, 32'(mute), 32'(e_c[6] | pin_mute));
        chk({tag, " R7 fmt"}, 32'(fmt), 32'(e_c[5:4] | pin_fmt));
        chk({tag, " R4 deemph"}, 32'(deem), 32'(e_c[3:2]));
    endtask

    task automatic model(input logic [15:0] w, input int nb);
        logic [13:0] p;
        p = pay_of(w);
        e_vln = 1'b0; e_vrn = 1'b0; e_srst = 1'b0; e_err = 1'b0;
        if (nb != 16) e_err = 1'b1;
        else case (w[1:0])
            2'b00: begin e_l = p; e_vln = 1'b1; end
            2'b10: begin e_r = p; e_vrn = 1'b1; end
            2'b01: begin e_c = p; e_srst = p[7]; e_c[7] = 1'b0; end
            default: ;
        endcase
    endtask

    // Shift nb bits (low nb bits of w, MSB first), then latch; checks R10 timing
    task automatic send(input logic [31:0] w, input int nb, input string tag);
        for (int i = nb - 1; i >= 0; i--) begin
            ser_clk = 1'b0;
            ser_dat = w[i];
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        ser_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        model(w[15:0], nb);
        ser_lat = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({tag, " R10 no early strobe"}, 32'({vl_new, vr_new, dprst, ferr}), 32'(0));
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 left strobe"}, 32'(vl_new), 32'(e_vln));
        chk({tag, " R3 right strobe"}, 32'(vr_new), 32'(e_vrn));
        chk({tag, " R8 reset pulse"}, 32'(dprst), 32'(e_srst));
        chk({tag, " R6 frame error"}, 32'(ferr), 32'(e_err));
        check_regs(tag);
        @(negedge clk);
        chk({tag, " R1 strobes one cycle"}, 32'({vl_new, vr_new, dprst, ferr}), 32'(0));
        ser_lat = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] w;
        int nb;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9: reset state
        chk("R9 reset strobes", 32'({vl_new, vr_new, dprst, ferr}), 32'(0));
        check_regs("R9 reset");

        // Directed corners
        send(32'h0000_ABCC, 16, "dir R2 left");          // addr 00
        send(32'h0000_5556, 16, "dir R3 right");         // addr 10
        send(32'h0000_0D75, 16, "dir R4 control");       // addr 01, wlen/fmt/deemph set
        send(32'h0000_FFFF, 16, "dir R5 addr11");        // addr 11 ignored
        send(32'h0000_0201, 16, "dir R8 soft reset");    // payload bit 7 set
        send(32'h0000_1234, 15, "dir R6 short frame");
        send(32'h0001_2340, 17, "dir R6 long frame");
        send(32'h0000_0000, 0,  "dir R6 empty frame");
        send(32'h0000_8001, 16, "dir R1 msb first");     // control bit 13 only

        // R7: pins OR in combinationally
        pin_x2 = 1'b1; pin_mute = 1'b1; pin_fmt = 2'b10;
        @(negedge clk);
        check_regs("dir R7 pins high");
        pin_x2 = 1'b0; pin_x4 = 1'b1; pin_mute = 1'b0; pin_fmt = 2'b01;
        @(negedge clk);
        check_regs("dir R7 pins swap");

        // Random frames, random pins
        for (int k = 0; k < 45; k++) begin
            w  = $urandom;
            nb = (($urandom % 8) == 0) ? int'($urandom % 20) : 16;
            pin_x2   = 1'($urandom);
            pin_x4   = 1'($urandom);
            pin_mute = 1'($urandom);
            pin_fmt  = 2'($urandom);
            if (nb != 16) w = w & ((32'd1 << nb) - 1);
            send(w, nb, "rand R1");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule